// File: doc/BRIEF.md
# Host-Clocked Serial Result Shifter

This block sends an 18-bit conversion result to a host one bit at a time, using a serial clock that the host supplies. The host frames a transfer by driving chip select and the read strobe low. The block then presents the most significant bit on its serial data output and advances one bit on each host clock edge. The host clock is asynchronous to the block. A two-flop synchronizer brings it into the system clock domain, and an edge detector follows the synchronizer. The system clock must run at least four times faster than the host clock.

The level of the host clock at the moment chip select falls is taken as its idle level. The shifter advances on every edge that leaves that level. This one rule covers bursts that idle low, bursts that idle high, and a clock that runs without stopping. A mode input sets when reading is allowed. In read-after mode, edges are ignored while the converter is busy. In read-during mode, the previous result is read while the next conversion is running.

Host clock edges late in a conversion can disturb the converter's decisions. For this reason the block watches for any host clock edge in the second half of the busy period and raises a sticky warning flag when it sees one. The flag clears when the next conversion starts.

Top module: `slave_serial_shifter`

## Requirements
- R1: While reset is held and after it is released, `sdout` is 0 and `late_edge_flag` is 0.
- R2: In an active frame, `sdout` shows bit 17 of `result_in` before the first shift edge. Each accepted shift edge moves `sdout` to the next lower bit, so the bits leave most significant first. A shift edge takes effect on the third system clock edge after the host clock transition.
- R3: Host clock edges advance the shifter only while both `cs_n` and `rd_n` are low. While `rd_n` is high, edges are ignored and `sdout` keeps showing bit 17.
- R4: While `ext_clk_sel` is 0 (slave operation off), no shifting takes place and `sdout` stays 0.
- R5: The synchronized host clock level seen when `cs_n` falls is the idle level. Only edges that leave the idle level shift. Correct data results for bursts idling low, bursts idling high, and a free-running clock.
- R6: After 18 accepted edges, `sdout` is 0 until `cs_n` rises, and further edges have no effect. `cs_n` high resets the bit count, so the next frame starts again at bit 17. Outside a frame, `sdout` is 0.
- R7: With `read_during` = 0, edges are ignored while `busy` is 1. With `read_during` = 1, edges are accepted while `busy` is 1.
- R8: Any host clock edge, in either direction and regardless of framing, that is detected while `busy` has been high for at least `HALF_CYCLES` system cycles sets `late_edge_flag`. The flag then stays set while `busy` falls and stays low.
- R9: A rising edge of `busy` (a conversion start) clears `late_edge_flag` one cycle later.
- R10: A host clock edge detected within the first `HALF_CYCLES` cycles of `busy` does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Host serial clock (asynchronous) |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| rd_n | input | 1 | Read strobe, active low, synchronous to clk |
| ext_clk_sel | input | 1 | 1 selects slave operation with the host clock |
| read_during | input | 1 | 1 = read during the next conversion, 0 = read after conversion |
| busy | input | 1 | Conversion in progress |
| result_in | input | RES_W | Latched conversion result |
| sdout | output | 1 | Serial data, MSB first |
| late_edge_flag | output | 1 | Sticky warning: host clock edge in late conversion |

## Verification
The in-line assertions check four things on every cycle: the bit count stays bounded, a high `cs_n` clears the count, a high `rd_n` freezes the count, and `sdout` is 0 once all bits have gone. They also check that the warning flag stays set until a conversion start and that it clears on that start. Only the bench scenarios can show the order and values of the bits. These scenarios cover the three clock styles, the choice of the correct edge polarity (which requires sampling between the leaving and returning edges), the mode gating against `busy`, and the split between early and late edges in a conversion.

// File: rtl/sss_pkg.sv
// Package: shared sizing helpers for the host-clocked serial shifter.
// Assumes nothing beyond standard integer arithmetic.
package sss_pkg;
    localparam int DEF_RES_W       = 18;
    localparam int DEF_HALF_CYCLES = 16;
    localparam int DEF_SYNC_STAGES = 2;

    // Width needed to count from 0 up to and including n.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/sss_sync_edge.sv
// Module: synchronizes the asynchronous host clock into the system domain
// and flags any change of its synchronized level.
// Assumes the system clock is at least four times the host clock, so that
// every host level is held for two or more system cycles.
module sss_sync_edge #(
    parameter int STAGES = sss_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic any_edge
);
    logic [STAGES:0] pipe;

    // Shift the asynchronous input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign level    = pipe[STAGES-1];
    assign any_edge = pipe[STAGES-1] ^ pipe[STAGES];
endmodule

// File: rtl/sss_shift_core.sv
// Module: frame tracking, idle-level capture, bit counter and shift register.
// Assumes cs_n and rd_n are synchronous to clk; level/any_edge come from the
// synchronizer. An edge shifts only when it leaves the idle level latched at
// the falling edge of cs_n.
module sss_shift_core #(
    parameter int RES_W = sss_pkg::DEF_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             slave_on,
    input  logic             mode_ok,
    input  logic             level,
    input  logic             any_edge,
    input  logic [RES_W-1:0] result_in,
    output logic             sdout
);
    localparam int CNT_W = sss_pkg::cnt_width(RES_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RES_W);

    logic             cs_q;
    logic             idle_lvl;
    logic [CNT_W-1:0] bit_cnt;
    logic [RES_W-1:0] shreg;
    logic             frame, cs_fall, leave_idle, accept;

    assign frame      = !cs_n && !cs_q;
    assign cs_fall    = !cs_n && cs_q;
    assign leave_idle = any_edge && (level != idle_lvl);
    assign accept     = frame && leave_idle && !rd_n && slave_on && mode_ok
                        && (bit_cnt != LAST);

    // Remember the previous chip select to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // Latch the host clock idle level at the start of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       idle_lvl <= 1'b0;
        else if (cs_fall) idle_lvl <= level;
    end

    // Count accepted bits; chip select high restarts the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) bit_cnt <= '0;
        else if (accept)    bit_cnt <= bit_cnt + 1'b1;
    end

    // Shift the result, taking a fresh copy on the first accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      shreg <= '0;
        else if (accept) shreg <= ((bit_cnt == '0) ? result_in : shreg) << 1;
    end

    // Drive the current bit, or 0 outside a frame and after the last bit.
    always_comb begin
        if (frame && slave_on && (bit_cnt != LAST))
            sdout = (bit_cnt == '0) ? result_in[RES_W-1] : shreg[RES_W-1];
        else
            sdout = 1'b0;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST) else $error("bit count out of range"); // R6
    AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (bit_cnt == '0)) else $error("count not cleared"); // R6
    AST_RD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rd_n) |=> $stable(bit_cnt)) else $error("shift with rd_n high"); // R3
    AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == LAST) |-> !sdout) else $error("data after last bit"); // R6
endmodule

// File: rtl/sss_busy_watch.sv
// Module: times the busy period and raises a sticky flag when a host clock
// edge arrives in its second half. Assumes busy is synchronous to clk and
// that a conversion start is a rising edge of busy.
module sss_busy_watch #(
    parameter int HALF_CYCLES = sss_pkg::DEF_HALF_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic any_edge,
    output logic flag
);
    localparam int TW = sss_pkg::cnt_width(HALF_CYCLES);
    localparam logic [TW-1:0] HALF = TW'(HALF_CYCLES);

    logic          busy_q;
    logic [TW-1:0] busy_age;
    logic          conv_start, late;

    assign conv_start = busy && !busy_q;
    assign late       = busy && (busy_age == HALF);

    // Delay busy by one cycle to find conversion starts.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Count cycles spent in busy, saturating at the half-way mark.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)    busy_age <= '0;
        else if (busy_age != HALF) busy_age <= busy_age + 1'b1;
    end

    // Set on a late edge, clear on the next conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b0;
        else if (conv_start)       flag <= 1'b0;
        else if (late && any_edge) flag <= 1'b1;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !conv_start) |=> flag) else $error("flag dropped"); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !flag) else $error("flag not cleared"); // R9
endmodule

// File: rtl/slave_serial_shifter.sv
// Module: top of the host-clocked serial result shifter. Connects the
// synchronizer, the shift core and the busy watcher. Assumes clk is at
// least four times the host clock and that cs_n, rd_n, busy are clk-synchronous.
module slave_serial_shifter #(
    parameter int RES_W       = sss_pkg::DEF_RES_W,
    parameter int HALF_CYCLES = sss_pkg::DEF_HALF_CYCLES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_in,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             ext_clk_sel,
    input  logic             read_during,
    input  logic             busy,
    input  logic [RES_W-1:0] result_in,
    output logic             sdout,
    output logic             late_edge_flag
);
    logic sclk_lvl, sclk_edge, mode_ok;

    // Read-after mode holds the shifter while a conversion is running.
    assign mode_ok = read_during || !busy;

    sss_sync_edge #(.STAGES(sss_pkg::DEF_SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sclk_in),
        .level(sclk_lvl), .any_edge(sclk_edge)
    );

    sss_shift_core #(.RES_W(RES_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
        .slave_on(ext_clk_sel), .mode_ok(mode_ok),
        .level(sclk_lvl), .any_edge(sclk_edge),
        .result_in(result_in), .sdout(sdout)
    );

    sss_busy_watch #(.HALF_CYCLES(HALF_CYCLES)) u_watch (
        .clk(clk), .rst_n(rst_n), .busy(busy), .any_edge(sclk_edge),
        .flag(late_edge_flag)
    );

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_clk_sel |-> !sdout) else $error("data while slave off"); // R4
endmodule

// File: tb/slave_serial_shifter_tb_top.sv
// Bench: scoreboard. Driver tasks push expected values into a queue and
// fire a sample event; a monitor pops and compares against the ports.
module slave_serial_shifter_tb_top;
    localparam int CLK_P = 10;
    localparam int HALF_SCLK = 4;

    logic clk = 1'b0, rst_n = 1'b0, sclk_in = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
    logic ext_clk_sel = 1'b1, read_during = 1'b0, busy = 1'b0;
    logic [17:0] result_in = '0;
    logic sdout, late_edge_flag;

    typedef struct { logic exp_v; bit is_flag; string tag; } item_t;
    item_t exp_q[$];
    event sample_ev;
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    slave_serial_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n(cs_n), .rd_n(rd_n),
        .ext_clk_sel(ext_clk_sel), .read_during(read_during), .busy(busy),
        .result_in(result_in), .sdout(sdout), .late_edge_flag(late_edge_flag)
    );

    // Monitor: compare each queued expectation with the output it names.
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic act;
                it  = exp_q.pop_front();
                act = it.is_flag ? late_edge_flag : sdout;
                n_checks++;
                if (act !== it.exp_v) begin
                    n_fail++;
                    $display("FAIL %s %s: actual %b expected %b", it.tag,
                             it.is_flag ? "late_edge_flag" : "sdout", act, it.exp_v);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_v(input bit is_flag, input logic v, input string tag);
        item_t it;
        it.exp_v = v; it.is_flag = is_flag; it.tag = tag;
        exp_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    // Driver: one 18-edge frame. kind 0 = shifts, 1 = held at MSB, 2 = silent.
    task automatic run_frame(input logic [17:0] w, input logic idle, input bit cont,
                             input bit rd, input int kind, input string tag);
        result_in = w;
        sclk_in   = idle;
        if (cont) begin
            for (int i = 0; i < 3; i++) begin sclk_in = ~sclk_in; tick(HALF_SCLK); end
            sclk_in = ~sclk_in;   // back to idle, clock keeps running
            tick(HALF_SCLK - 1);
        end else begin
            tick(HALF_SCLK);
        end
        cs_n = 1'b0; rd_n = rd ? 1'b0 : 1'b1;
        tick(1);
        for (int k = 0; k < 18; k++) begin
            logic before_v, after_v;
            before_v = (kind == 0) ? w[17-k] : (kind == 1) ? w[17] : 1'b0;
            after_v  = (kind == 0) ? ((k < 17) ? w[16-k] : 1'b0) : before_v;
            expect_v(0, before_v, tag);
            sclk_in = ~idle;      // edge leaving idle
            tick(HALF_SCLK);
            expect_v(0, after_v, tag);
            sclk_in = idle;       // returning edge
            tick(HALF_SCLK);
        end
        // Extra edges after the last bit change nothing (R6).
        sclk_in = ~idle; tick(HALF_SCLK); sclk_in = idle; tick(HALF_SCLK);
        expect_v(0, (kind == 1) ? w[17] : 1'b0, (kind == 0) ? "R6" : tag);
        cs_n = 1'b1; rd_n = 1'b1;
        tick(2);
        expect_v(0, 1'b0, "R6");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_v(0, 1'b0, "R1");
        expect_v(1, 1'b0, "R1");
        rst_n = 1'b1;
        tick(4);
        expect_v(0, 1'b0, "R1");
        expect_v(1, 1'b0, "R1");

        run_frame(18'h2B5A3, 1'b0, 0, 1, 0, "R2");   // burst idle low
        run_frame(18'h1C36F, 1'b1, 0, 1, 0, "R5");   // burst idle high
        run_frame(18'h30F0C, 1'b0, 1, 1, 0, "R5");   // free-running, low at frame start
        run_frame(18'h0A5E1, 1'b1, 1, 1, 0, "R5");   // free-running, high at frame start
        run_frame(18'h3FFFF, 1'b0, 0, 1, 0, "R6");   // next frame restarts at bit 17
        run_frame(18'h2AAAA, 1'b0, 0, 0, 1, "R3");   // rd_n high: edges ignored
        ext_clk_sel = 1'b0;
        run_frame(18'h3ABCD, 1'b0, 0, 1, 2, "R4");   // slave off
        ext_clk_sel = 1'b1;

        read_during = 1'b0; busy = 1'b1; tick(2);
        run_frame(18'h25555, 1'b0, 0, 1, 1, "R7");   // read-after while busy: held
        read_during = 1'b1;
        run_frame(18'h1E3C7, 1'b0, 0, 1, 0, "R7");   // read-during while busy: shifts
        busy = 1'b0; read_during = 1'b0; tick(4);

        // Late-edge warning flag.
        sclk_in = 1'b0; tick(4);
        busy = 1'b1; tick(2);
        expect_v(1, 1'b0, "R9");
        sclk_in = 1'b1; tick(5);                     // early edge
        expect_v(1, 1'b0, "R10");
        tick(20);
        sclk_in = 1'b0; tick(5);                     // late edge
        expect_v(1, 1'b1, "R8");
        busy = 1'b0; tick(6);
        expect_v(1, 1'b1, "R8");
        busy = 1'b1; tick(2);
        expect_v(1, 1'b0, "R9");
        busy = 1'b0; tick(4);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule